// File: doc/BRIEF.md
# Logical-to-Physical Segment Translator

This block widens 32-bit logical addresses into a 36-bit physical address space. A table of sixteen programmable segment descriptors, each 64 bits wide, defines power-of-two sized windows in the logical space. Each window carries a 24-bit physical replacement base and read, write and execute permissions. A lookup replaces the upper address bits that lie above the segment size with the descriptor's physical bits and keeps the offset bits unchanged. When windows overlap, the descriptor with the highest index decides the result.

Software or a boot sequencer writes descriptors through a plain write strobe. Lookups arrive as a valid/ready stream and leave as a valid/ready stream. The response stage holds one result. A new request is accepted when that stage is empty or is being drained in the same cycle, so `req_ready = !rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value and no request is accepted. The result of an accepted request appears on the response port on the next clock edge.

Top module: `seg_xlate`

## Requirements
- R1: When `cfg_we` is high, `cfg_wdata` is written into descriptor `cfg_idx`. The field layout is: [63:44] logical base bits 31:12, [43:20] physical base bits 35:12, [19:15] size code, [2:0] permissions (bit0 read, bit1 write, bit2 execute), with [14:3] ignored. A lookup accepted in the same cycle as a write sees the old table, and a lookup accepted in any later cycle sees the new one.
- R2: A size code c from 11 to 31 gives a segment of 2^(c+1) bytes, so the smallest segment is 4 KB (c=11) and the largest is 4 GB (c=31). A size code below 11 disables the descriptor. Logical base bits below the segment size are ignored.
- R3: An address inside an enabled segment whose permissions allow the access kind responds with hit=1 and fault=0. The physical address takes its bits at and above the segment size from the physical base, and its bits below that from the logical address.
- R4: When more than one enabled descriptor contains the address, the descriptor with the highest index alone decides the response.
- R5: An address that matches no enabled descriptor responds with hit=0, fault=0 and physical address `{4'b0, logical}`.
- R6: Access kind encoding is 0 read, 1 write, 2 execute and 3 reserved. If the winning descriptor does not permit the kind, and kind 3 is never permitted, the response has fault=1 and hit=0, and its physical address is `{4'b0, logical}`. Hit and fault are never high together.
- R7: After reset, `rsp_valid` is low. Descriptor 0 maps logical 0x0000_0000 to 0x7FFF_FFFF as an identity map, and descriptor 1 does the same for 0x8000_0000 to 0xFFFF_FFFF. Both have all permissions and size code 30. All other descriptors reset disabled.
- R8: `req_ready = !rsp_valid || rsp_ready`. An accepted request produces `rsp_valid` on the next edge. While the response is stalled, the response outputs stay stable.
- R9: A descriptor with size code 31 matches every logical address, and its physical address is `{pbase[23:20], logical}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_wdata | input | 64 | Descriptor value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle when valid |
| req_addr | input | 32 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 36 | Physical address |
| rsp_hit | output | 1 | Permitted match |
| rsp_fault | output | 1 | Match without permission |

## Verification
Each lookup result is due one clock edge after the edge that accepts the request. The bench therefore drives a request at a falling edge and reads the response at the next falling edge after the accepting rising edge. A descriptor write takes effect for lookups accepted from the following edge onward. One test drives a write and a lookup in the same cycle and expects the old mapping, then expects the new one a cycle later. During back-pressure the bench samples at each falling edge of the stall and requires unchanged outputs and a low `req_ready`. It then expects the waiting request to be taken on the same edge that drains the stage.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LA_W     = 32;
  localparam int PA_W     = 36;
  localparam int OFF_W    = 12;
  localparam int LB_W     = LA_W - OFF_W;
  localparam int PB_W     = PA_W - OFF_W;
  localparam int DESC_W   = 64;
  localparam int CODE_W   = 5;
  localparam int MIN_CODE = OFF_W - 1;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_EX  = 2'd2,
    KIND_RSV = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [LB_W-1:0]   lbase;
    logic [PB_W-1:0]   pbase;
    logic [CODE_W-1:0] code;
    logic [2:0]        perm;   // bit0 read, bit1 write, bit2 execute
  } seg_desc_t;

  function automatic seg_desc_t unpack_desc(input logic [DESC_W-1:0] w);
    seg_desc_t d;
    d.lbase = w[63:44];
    d.pbase = w[43:20];
    d.code  = w[19:15];
    d.perm  = w[2:0];
    return d;
  endfunction

  function automatic seg_desc_t reset_desc(input int i);
    seg_desc_t d;
    d = '0;
    if (i == 0) begin
      d.code = 5'd30;
      d.perm = 3'b111;
    end else if (i == 1) begin
      d.lbase = 20'h80000;
      d.pbase = 24'h080000;
      d.code  = 5'd30;
      d.perm  = 3'b111;
    end
    return d;
  endfunction
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we_i,
  input  logic [IDX_W-1:0]          cfg_idx_i,
  input  logic [DESC_W-1:0]         cfg_wdata_i,
  output seg_desc_t [NUM_SEG-1:0]   desc_o
);
  seg_desc_t [NUM_SEG-1:0] tbl_q;
  logic unused_rsv;

  assign unused_rsv = ^cfg_wdata_i[14:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEG; i++) tbl_q[i] <= reset_desc(i);
    end else if (cfg_we_i) begin
      tbl_q[cfg_idx_i] <= unpack_desc(cfg_wdata_i);
    end
  end

  assign desc_o = tbl_q;

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> tbl_q[$past(cfg_idx_i)] == unpack_desc($past(cfg_wdata_i))); // R1
endmodule

// File: rtl/seg_entry_match.sv
module seg_entry_match
  import seg_xlate_pkg::*;
(
  input  seg_desc_t         desc_i,
  input  logic [LA_W-1:0]   addr_i,
  input  logic [1:0]        kind_i,
  output logic              match_o,
  output logic              allow_o,
  output logic [PA_W-1:0]   phys_o
);
  logic [PA_W+OFF_W-1:0] ext_addr;
  logic [PB_W-1:0]       ext_lbase;
  int                    code_int;

  assign ext_addr  = {{(PA_W+OFF_W-LA_W){1'b0}}, addr_i};
  assign ext_lbase = {{(PB_W-LB_W){1'b0}}, desc_i.lbase};
  assign code_int  = int'(desc_i.code);

  always_comb begin
    match_o = (code_int >= MIN_CODE);
    phys_o  = '0;
    phys_o[OFF_W-1:0] = addr_i[OFF_W-1:0];
    for (int j = 0; j < PB_W; j++) begin
      if (j + OFF_W > code_int) begin
        if (ext_addr[j+OFF_W] != ext_lbase[j]) match_o = 1'b0;
        phys_o[j+OFF_W] = desc_i.pbase[j];
      end else begin
        phys_o[j+OFF_W] = ext_addr[j+OFF_W];
      end
    end
  end

  always_comb begin
    unique case (kind_i)
      KIND_RD: allow_o = desc_i.perm[0];
      KIND_WR: allow_o = desc_i.perm[1];
      KIND_EX: allow_o = desc_i.perm[2];
      default: allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/seg_prio_pick.sv
module seg_prio_pick
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16
) (
  input  logic [NUM_SEG-1:0]            match_i,
  input  logic [NUM_SEG-1:0]            allow_i,
  input  logic [NUM_SEG-1:0][PA_W-1:0]  phys_i,
  output logic                          any_o,
  output logic                          allow_o,
  output logic [PA_W-1:0]               phys_o
);
  always_comb begin
    any_o   = 1'b0;
    allow_o = 1'b0;
    phys_o  = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (match_i[i]) begin
        any_o   = 1'b1;
        allow_o = allow_i[i];
        phys_o  = phys_i[i];
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [DESC_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_addr,
  input  logic [1:0]         req_kind,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_hit,
  output logic               rsp_fault
);
  seg_desc_t [NUM_SEG-1:0]           desc;
  logic [NUM_SEG-1:0]                match_v;
  logic [NUM_SEG-1:0]                allow_v;
  logic [NUM_SEG-1:0][PA_W-1:0]      phys_v;
  logic                              any_m, sel_allow;
  logic [PA_W-1:0]                   sel_phys;
  logic                              accept;
  logic [OFF_W-1:0]                  r_off;

  seg_desc_file #(.NUM_SEG(NUM_SEG)) desc_file_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .desc_o(desc)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    seg_entry_match entry_i (
      .desc_i(desc[g]), .addr_i(req_addr), .kind_i(req_kind),
      .match_o(match_v[g]), .allow_o(allow_v[g]), .phys_o(phys_v[g])
    );
  end

  seg_prio_pick #(.NUM_SEG(NUM_SEG)) pick_i (
    .match_i(match_v), .allow_i(allow_v), .phys_i(phys_v),
    .any_o(any_m), .allow_o(sel_allow), .phys_o(sel_phys)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      r_off     <= '0;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (accept) begin
        rsp_hit   <= any_m && sel_allow;
        rsp_fault <= any_m && !sel_allow;
        rsp_paddr <= (any_m && sel_allow) ? sel_phys
                                          : {{(PA_W-LA_W){1'b0}}, req_addr};
        r_off     <= req_addr[OFF_W-1:0];
      end
    end
  end

  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit) && $stable(rsp_fault))); // R8
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_fault)); // R6
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_paddr[OFF_W-1:0] == r_off); // R3
endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [63:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [35:0] rsp_paddr;
  logic        rsp_hit;
  logic        rsp_fault;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [63:0] mk(input logic [19:0] lb, input logic [23:0] pb,
                                     input logic [4:0] code, input logic [2:0] perm);
    return {lb, pb, code, 12'h000, perm};
  endfunction

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [1:0] k,
                      input logic eh, input logic ef, input logic [35:0] ep);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {39'd0, rsp_valid}, 40'd1);
    chk({tag, " hit"},   {39'd0, rsp_hit},   {39'd0, eh});
    chk({tag, " fault"}, {39'd0, rsp_fault}, {39'd0, ef});
    chk({tag, " paddr"}, {4'd0, rsp_paddr},  {4'd0, ep});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 rsp_valid after reset", {39'd0, rsp_valid}, 40'd0);
    chk("R8 ready when empty", {39'd0, req_ready}, 40'd1);
    look("R7 low identity", 32'h1234_5678, 2'd0, 1'b1, 1'b0, 36'h0_1234_5678);
    look("R7 high identity", 32'h9000_0010, 2'd2, 1'b1, 1'b0, 36'h0_9000_0010);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h1111_0000; req_kind = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 first rsp", {4'd0, rsp_paddr}, 40'h0_1111_0000);
    chk("R8 ready low while stalled", {39'd0, req_ready}, 40'd0);
    req_addr = 32'h2222_0004;
    for (int c = 0; c < 2; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R8 held paddr", {4'd0, rsp_paddr}, 40'h0_1111_0000);
      chk("R8 held valid", {39'd0, rsp_valid}, 40'd1);
      chk("R8 ready still low", {39'd0, req_ready}, 40'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second rsp", {4'd0, rsp_paddr}, 40'h0_2222_0004);
    chk("R8 second valid", {39'd0, rsp_valid}, 40'd1);
    @(negedge clk);
    chk("R8 drained", {39'd0, rsp_valid}, 40'd0);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd3; cfg_wdata = mk(20'h50000, 24'h777777, 5'd11, 3'b111);
    req_valid = 1'b1; req_addr = 32'h5000_0010; req_kind = 2'd0;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R1 same-cycle old table", {4'd0, rsp_paddr}, 40'h0_5000_0010);
    look("R1 new table", 32'h5000_0010, 2'd0, 1'b1, 1'b0, 36'h7_7777_7010);
  endtask

  task automatic t_translate();
    wr(4'd2, mk(20'h00100, 24'hABC000, 5'd15, 3'b011));
    look("R3 64KB segment", 32'h0010_1234, 2'd0, 1'b1, 1'b0, 36'hA_BC00_1234);
    look("R4 falls to lower index", 32'h0011_0000, 2'd0, 1'b1, 1'b0, 36'h0_0011_0000);
    wr(4'd5, mk(20'h00108, 24'h111110, 5'd14, 3'b001));
    look("R4 higher index wins", 32'h0010_9ABC, 2'd0, 1'b1, 1'b0, 36'h1_1111_1ABC);
    look("R4 outside inner segment", 32'h0010_0004, 2'd1, 1'b1, 1'b0, 36'hA_BC00_0004);
  endtask

  task automatic t_fault();
    look("R6 write denied", 32'h0010_9000, 2'd1, 1'b0, 1'b1, 36'h0_0010_9000);
    look("R6 exec denied", 32'h0010_9004, 2'd2, 1'b0, 1'b1, 36'h0_0010_9004);
    look("R6 reserved kind", 32'h0000_4000, 2'd3, 1'b0, 1'b1, 36'h0_0000_4000);
  endtask

  task automatic t_miss_and_size();
    wr(4'd0, 64'd0);
    wr(4'd1, 64'd0);
    look("R5 miss zero-extend", 32'h4000_0000, 2'd0, 1'b0, 1'b0, 36'h0_4000_0000);
    wr(4'd7, mk(20'h40000, 24'h123456, 5'd10, 3'b111));
    look("R2 code 10 disabled", 32'h4000_0008, 2'd0, 1'b0, 1'b0, 36'h0_4000_0008);
    wr(4'd8, mk(20'h40000, 24'hFFFFFF, 5'd11, 3'b111));
    look("R2 4KB top", 32'h4000_0FFF, 2'd0, 1'b1, 1'b0, 36'hF_FFFF_FFFF);
    look("R2 4KB beyond", 32'h4000_1000, 2'd0, 1'b0, 1'b0, 36'h0_4000_1000);
  endtask

  task automatic t_full_space();
    wr(4'd15, mk(20'hFFFFF, 24'h300000, 5'd31, 3'b111));
    look("R9 4GB segment", 32'hDEAD_BEEF, 2'd1, 1'b1, 1'b0, 36'h3_DEAD_BEEF);
    look("R9 overrides index 2", 32'h0010_1234, 2'd2, 1'b1, 1'b0, 36'h3_0010_1234);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_kind = '0; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_backpressure();
    t_write_timing();
    t_translate();
    t_fault();
    t_miss_and_size();
    t_full_space();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule